// File: doc/BRIEF.md
# Dual-Mode Numerically Controlled Oscillator

This block is a phase-accumulator frequency source. On every clock where it is enabled, it adds a programmable increment into a wide accumulator. Each carry out of that accumulator is an overflow event, and the overflow events drive one of two output shapers.

The toggle shaper flips a flip-flop on every overflow. While the increment is held constant, this gives a square wave with a 50% duty cycle. The pulse shaper starts a down-counter on every overflow. The output is active for 2^n clock periods, where n is a 3-bit width code.

The selected waveform passes through a final polarity inverter. The result is presented on the output pin and on a read-only status copy. A sticky interrupt flag records rising edges of the final output. This includes an edge caused only by changing the polarity input.

Control comes from register-level inputs: enable, mode, polarity, width code, increment, interrupt enable and flag clear.

Top module: `nco_dual_mode`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with `en` low, `irq_flag` is 0 and `nco_out` equals `pol` (pre-polarity level inactive).
- R2: On each clock with `en` high, the 20-bit accumulator adds the zero-extended 16-bit `inc` modulo 2^20. An overflow is the carry out of that add, so the overflow spacing follows `inc` exactly, including for increments that do not divide 2^20.
- R3: With `mode`=0 (toggle mode), the pre-polarity output flips on the same clock edge at which the accumulator overflows, and at no other edge.
- R4: With `mode`=1 (pulse mode), the pre-polarity output becomes active on the clock edge of each overflow and stays active for exactly 2^`pws` clock periods. This holds for `pws` from 0 to 7, as long as that width is shorter than the overflow spacing.
- R5: The `mode` input selects the waveform at any time: 0 selects the toggle shaper and 1 selects the pulse shaper. Both shapers keep running, so switching mode shows the other shaper's current level at once.
- R6: `nco_out` equals the pre-polarity level XOR `pol`. A change of `pol` changes `nco_out` in the same cycle.
- R7: `nco_stat` always carries the same value as `nco_out`.
- R8: A clock edge with `en` low clears the accumulator, the toggle flip-flop and the pulse counter. The next cycle therefore shows `nco_out` equal to `pol`, and after re-enabling, counting restarts from zero.
- R9: With `irq_en` high, a rising edge of `nco_out` sets `irq_flag` one clock later. This includes a rise caused only by `pol`. The flag then holds until `irq_clr` is high at a clock edge with no new rise, because a rise takes priority over a clear.
- R10: With `irq_en` low, `irq_flag` is never set, whatever `nco_out` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the accumulator and both shapers |
| mode | input | 1 | 0 = toggle on overflow, 1 = stretched pulse |
| pol | input | 1 | 1 inverts the final output |
| pws | input | 3 | Pulse width code n, giving a width of 2^n clocks |
| inc | input | 16 | Phase increment, zero-extended |
| irq_en | input | 1 | Allows output rising edges to set the flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| nco_out | output | 1 | Final oscillator output |
| nco_stat | output | 1 | Read-only status copy of the final output |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default parameters: a 20-bit accumulator, a 16-bit increment and a 3-bit width code.

An increment of 0x8000 gives an overflow every 32 clocks. This makes toggle periods and the shorter pulse widths easy to count. An increment of 0x1000 spreads overflows 256 clocks apart, which brings the widest code (128 clocks) within reach without entering the undefined region. An odd increment of 0x3333 exercises uneven wrap remainders.

// File: rtl/nco_pkg.sv
package nco_pkg;

   typedef enum logic {
      SHAPE_TOGGLE = 1'b0,
      SHAPE_PULSE  = 1'b1
   } nco_shape_e;

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 20,
   parameter int INC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic             ovf
);
   localparam int PAD_W = ACC_W - INC_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc_ext;
   logic [ACC_W:0]   sum;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign inc_ext = inc;
      end else begin : g_pad
         assign inc_ext = {{PAD_W{1'b0}}, inc};
      end
   endgenerate

   assign sum = {1'b0, acc_q} + {1'b0, inc_ext};
   assign ovf = en & sum[ACC_W];

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         acc_q <= '0;
      end else begin
         acc_q <= sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/nco_toggle.sv
module nco_toggle (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic ovf,
   output logic tog
);
   logic tog_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         tog_q <= 1'b0;
      end else if (ovf) begin
         tog_q <= ~tog_q;
      end
   end

   assign tog = tog_q;
endmodule

// File: rtl/nco_pulse_stretch.sv
module nco_pulse_stretch #(
   parameter int PWS_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             ovf,
   input  logic [PWS_W-1:0] pws,
   output logic             active
);
   // the longest width is 2^(2^PWS_W - 1), which fits in 2^PWS_W bits
   localparam int CNT_W = 2 ** PWS_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign load_val = {{(CNT_W-1){1'b0}}, 1'b1} << pws;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt_q <= '0;
      end else if (ovf) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage
   import nco_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  nco_shape_e shape,
   input  logic       tog,
   input  logic       pulse,
   input  logic       pol,
   input  logic       irq_en,
   input  logic       irq_clr,
   output logic       out,
   output logic       irq
);
   logic pre;
   logic prev_q;
   logic irq_q;
   logic rise;

   assign pre  = (shape == SHAPE_PULSE) ? pulse : tog;
   assign out  = pre ^ pol;
   assign rise = out & ~prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= out;
         if (irq_en && rise) begin
            irq_q <= 1'b1;
         end else if (irq_clr) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq = irq_q;
endmodule

// File: rtl/nco_dual_mode.sv
module nco_dual_mode
   import nco_pkg::*;
#(
   parameter int ACC_W = 20,
   parameter int INC_W = 16,
   parameter int PWS_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             mode,
   input  logic             pol,
   input  logic [PWS_W-1:0] pws,
   input  logic [INC_W-1:0] inc,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic             nco_out,
   output logic             nco_stat,
   output logic             irq_flag
);
   generate
      if (INC_W < 1 || INC_W > ACC_W) begin : g_bad_inc
         $error("nco_dual_mode: INC_W must lie in 1..ACC_W");
      end
      if (PWS_W < 1 || PWS_W > 4) begin : g_bad_pws
         $error("nco_dual_mode: PWS_W must lie in 1..4");
      end
   endgenerate

   logic       ovf_w;
   logic       tog_w;
   logic       pulse_w;
   logic       out_w;
   nco_shape_e shape_w;

   assign shape_w = nco_shape_e'(mode);

   nco_phase_acc #(.ACC_W(ACC_W), .INC_W(INC_W)) u_acc (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .inc (inc),
      .ovf (ovf_w)
   );

   nco_toggle u_tog (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .ovf (ovf_w),
      .tog (tog_w)
   );

   nco_pulse_stretch #(.PWS_W(PWS_W)) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .ovf    (ovf_w),
      .pws    (pws),
      .active (pulse_w)
   );

   nco_out_stage u_out (
      .clk     (clk),
      .rst     (rst),
      .shape   (shape_w),
      .tog     (tog_w),
      .pulse   (pulse_w),
      .pol     (pol),
      .irq_en  (irq_en),
      .irq_clr (irq_clr),
      .out     (out_w),
      .irq     (irq_flag)
   );

   assign nco_out  = out_w;
   assign nco_stat = out_w;
endmodule

// File: rtl/nco_dual_mode_chk.sv
module nco_dual_mode_chk (
   input logic clk,
   input logic rst,
   input logic en,
   input logic mode,
   input logic pol,
   input logic irq_en,
   input logic irq_clr,
   input logic ovf,
   input logic tog,
   input logic nco_out,
   input logic irq_flag
);
   // R3
   tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |=> (tog != $past(tog)));

   // R4
   pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
      (mode && ovf) |=> (!mode || (nco_out != pol)));

   // R8
   disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (nco_out == pol));

   // R9
   irq_set_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_en && nco_out && !$past(nco_out)) |=> irq_flag);

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (!irq_flag && !irq_en) |=> !irq_flag);
endmodule

bind nco_dual_mode nco_dual_mode_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .mode     (mode),
   .pol      (pol),
   .irq_en   (irq_en),
   .irq_clr  (irq_clr),
   .ovf      (ovf_w),
   .tog      (tog_w),
   .nco_out  (nco_out),
   .irq_flag (irq_flag)
);

// File: tb/nco_dual_mode_test.sv
module nco_dual_mode_test;
   localparam int CLK_PERIOD = 10;
   localparam int WRAP = 1 << 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic        mode = 1'b0;
   logic        pol = 1'b0;
   logic [2:0]  pws = 3'd0;
   logic [15:0] inc = 16'h8000;
   logic        irq_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic        nco_out;
   logic        nco_stat;
   logic        irq_flag;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   typedef struct {
      bit    out;
      bit    irq;
      string req;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_dual_mode uut (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .mode     (mode),
      .pol      (pol),
      .pws      (pws),
      .inc      (inc),
      .irq_en   (irq_en),
      .irq_clr  (irq_clr),
      .nco_out  (nco_out),
      .nco_stat (nco_stat),
      .irq_flag (irq_flag)
   );

   // reference model built from the requirements; pushes expected items
   int m_acc = 0;
   int m_cnt = 0;
   bit m_tog = 1'b0;
   bit m_prev = 1'b0;
   bit m_irq = 1'b0;

   always @(posedge clk) begin
      bit   cur;
      int   nxt;
      exp_t item;
      if (rst) begin
         m_acc = 0; m_cnt = 0; m_tog = 1'b0; m_prev = 1'b0; m_irq = 1'b0;
      end else begin
         cur = (mode ? (m_cnt != 0) : m_tog) ^ pol;
         if (irq_en && cur && !m_prev) m_irq = 1'b1;
         else if (irq_clr) m_irq = 1'b0;
         m_prev = cur;
         if (!en) begin
            m_acc = 0; m_cnt = 0; m_tog = 1'b0;
         end else begin
            nxt = m_acc + int'(inc);
            if (m_cnt != 0) m_cnt = m_cnt - 1;
            if (nxt >= WRAP) begin
               nxt = nxt - WRAP;
               m_tog = ~m_tog;
               m_cnt = 1 << pws;
            end
            m_acc = nxt;
         end
      end
      item.out = (mode ? (m_cnt != 0) : m_tog) ^ pol;
      item.irq = m_irq;
      item.req = tag;
      sb_q.push_back(item);
   end

   // monitor: pops one item per cycle and compares away from the edge
   always @(negedge clk) begin
      exp_t e;
      if (sb_q.size() > 0 && !done) begin
         e = sb_q.pop_front();
         checks++;
         if (nco_out !== e.out) begin
            errors++;
            $display("FAIL %s nco_out actual %b expected %b at %0t", e.req, nco_out, e.out, $time);
         end
         checks++;
         if (nco_stat !== e.out) begin
            errors++;
            $display("FAIL R7 nco_stat actual %b expected %b at %0t", nco_stat, e.out, $time);
         end
         checks++;
         if (irq_flag !== e.irq) begin
            errors++;
            $display("FAIL %s irq_flag actual %b expected %b at %0t", e.req, irq_flag, e.irq, $time);
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      tag = "R1";
      step(4);
      rst = 1'b0;
      step(3);
      // R3: toggle mode, 32-clock overflow spacing
      tag = "R3";
      en = 1'b1;
      step(100);
      // R2: uneven wrap remainders
      tag = "R2";
      inc = 16'h3333;
      step(150);
      // R5: switch to pulse mode while running
      tag = "R5";
      inc = 16'h8000;
      mode = 1'b1;
      step(40);
      mode = 1'b0;
      step(20);
      mode = 1'b1;
      // R4: pulse widths 1, 8, 16 and 128 clocks
      tag = "R4";
      pws = 3'd0;
      step(100);
      pws = 3'd3;
      step(100);
      pws = 3'd4;
      step(70);
      inc = 16'h1000;
      pws = 3'd7;
      step(600);
      // R6: polarity inversion in both modes
      tag = "R6";
      pol = 1'b1;
      step(300);
      mode = 1'b0;
      inc = 16'h8000;
      step(80);
      pol = 1'b0;
      step(10);
      // R8: disable clears and restarts
      tag = "R8";
      en = 1'b0;
      step(10);
      en = 1'b1;
      step(70);
      // R9: flag on output rises, sticky, cleared by irq_clr
      tag = "R9";
      irq_en = 1'b1;
      step(40);
      irq_en = 1'b0;
      step(20);
      irq_clr = 1'b1;
      step(1);
      irq_clr = 1'b0;
      step(5);
      // R9: rise caused only by polarity
      en = 1'b0;
      irq_en = 1'b1;
      step(3);
      pol = 1'b1;
      step(5);
      irq_clr = 1'b1;
      step(1);
      irq_clr = 1'b0;
      step(3);
      pol = 1'b0;
      step(3);
      // R10: masked rises never set the flag
      tag = "R10";
      irq_en = 1'b0;
      pol = 1'b1;
      step(3);
      pol = 1'b0;
      en = 1'b1;
      mode = 1'b1;
      pws = 3'd2;
      step(100);
      step(2);
      finish_run();
   end
endmodule